// File: doc/BRIEF.md
# Block Write-Verify Command Sequencer

This block takes a ten-byte storage command descriptor, one byte per accepted beat, and carries out one of two commands against a plain block medium: a write that is then checked (opcode 2Eh) or a check of data already stored (opcode 2Fh). Initiator data arrives on a second byte stream, and each block of it is taken exactly once. The block is held in a one-block buffer, written from there to the medium and then read back. With byte checking on, every stored byte is compared with the buffered copy. With it off, no data is compared and a medium-integrity input decides the result.

A write-same option sends the one received block to every block of a range. When that option is set, a zero count means the range runs from the start address to the last block of the medium. Without it, a zero count means no work and good status. Ranges that do not fit on the medium are refused before anything is written. Each command ends with a one-cycle completion pulse that carries a status byte and a sense key.

Top module: `wv_cmd_sequencer`

## Requirements
- R1: Descriptor bytes are taken only while idle (`cdb_ready` high), in the order byte 0 to byte 9. Byte 0 is the opcode. Byte 1 bit 2 is write-same and bit 1 is byte-check. Bytes 2..5 hold the 32-bit start block and bytes 7..8 hold the 16-bit count, most significant byte first in both. Bytes 6 and 9 and the other bits of byte 1 have no effect.
- R2: An opcode other than 2Eh or 2Fh completes with status 02h and sense 5h. No data is taken and no medium write occurs.
- R3: For opcode 2Eh, each block is taken once as 16 bytes, written to offsets 0..15 of blocks L, L+1, and so on, then read back. A clean run completes with status 00h and sense 0h.
- R4: With byte-check set, the first read byte that differs from the buffered byte ends the command with status 02h and sense Eh. Later blocks are neither taken nor written.
- R5: With byte-check clear, no data comparison is made, so a differing stored byte still gives status 00h. A low `med_chk_ok` on a read cycle ends the command with status 02h and sense 3h. With byte-check set, `med_chk_ok` has no effect.
- R6: A count of zero without write-same completes with status 00h. No data is taken and nothing is written, for both opcodes.
- R7: With write-same set on opcode 2Eh and a count N, exactly one block of 16 bytes is taken and the same bytes are written to blocks L..L+N-1.
- R8: With write-same set and a count of zero, blocks L through the last block (capacity-1) are written.
- R9: A range with L+N above the capacity, or a write-same zero-count start at or above the capacity, completes with status 02h and sense 5h, with no data taken and no write. A range ending exactly at the capacity is accepted.
- R10: For opcode 2Fh, no writes occur. With byte-check set, one block of data is taken per block and compared with the stored bytes. With byte-check clear, no data is taken. Byte 1 bit 2 has no effect for this opcode.
- R11: `done` is high for exactly one cycle per command, with `status` and `sense` valid in that cycle. `cdb_ready` is low from the last descriptor byte until after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cdb_valid | input | 1 | Descriptor byte offered |
| cdb_ready | output | 1 | Descriptor byte taken (idle only) |
| cdb_byte | input | 8 | Descriptor byte |
| dout_valid | input | 1 | Initiator data byte offered |
| dout_ready | output | 1 | Initiator data byte taken |
| dout_byte | input | 8 | Initiator data byte |
| med_we | output | 1 | Medium write strobe |
| med_re | output | 1 | Medium read strobe |
| med_lba | output | LBA_W | Medium block address |
| med_off | output | OFF_W | Byte offset within block |
| med_wdata | output | 8 | Medium write data |
| med_rdata | input | 8 | Medium read data for the current address, same cycle |
| med_chk_ok | input | 1 | Medium integrity result on read cycles |
| done | output | 1 | Completion pulse |
| status | output | 8 | 00h good, 02h check condition |
| sense | output | 4 | 0h none, 3h medium error, 5h illegal request, Eh miscompare |

## Verification
The risky coincidence is a byte mismatch on the last offset of the last block. In that cycle the compare and the end-of-range count reach the completion decision together, and the error must win over good status. The bench provokes it with a medium model that corrupts offset 15 of a single-block write. It then requires status 02h with sense Eh rather than 00h. A second coincidence sets byte-check while holding `med_chk_ok` low, and the bench checks that only the compare result reaches the status.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
  localparam int CDB_LEN = 10;

  localparam logic [7:0] OP_WRV   = 8'h2E;
  localparam logic [7:0] OP_VFY   = 8'h2F;
  localparam logic [7:0] ST_GOOD  = 8'h00;
  localparam logic [7:0] ST_CHECK = 8'h02;

  localparam logic [3:0] SK_NONE    = 4'h0;
  localparam logic [3:0] SK_MEDIUM  = 4'h3;
  localparam logic [3:0] SK_ILLEGAL = 4'h5;
  localparam logic [3:0] SK_MISCMP  = 4'hE;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECODE,
    S_RECV,
    S_WRITE,
    S_VERIFY,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic        wsame;
    logic        bytchk;
    logic [31:0] lba;
    logic [15:0] count;
  } cmd_t;
endpackage

// File: rtl/wvs_rst_sync.sv
module wvs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/wvs_cdb_capture.sv
module wvs_cdb_capture
  import wvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       last_take,
  output cmd_t       cmd
);
  localparam int IDX_W = $clog2(CDB_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CDB_LEN - 1);

  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 take;
  logic [CDB_LEN*8-1:0] flat;

  assign in_ready  = en;
  assign take      = en & in_valid;
  assign last_take = take && (idx_q == IDX_LAST);

  always_comb begin
    idx_d = idx_q;
    if (take) idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < CDB_LEN; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               b_q <= '0;
      else if (take && idx_q == IDX_W'(g))      b_q <= in_byte;
    end
    assign flat[g*8 +: 8] = b_q;
  end

  assign cmd.opcode = flat[0*8 +: 8];
  assign cmd.wsame  = flat[1*8 + 2];
  assign cmd.bytchk = flat[1*8 + 1];
  assign cmd.lba    = {flat[2*8 +: 8], flat[3*8 +: 8], flat[4*8 +: 8], flat[5*8 +: 8]};
  assign cmd.count  = {flat[7*8 +: 8], flat[8*8 +: 8]};

  logic unused_fields;
  assign unused_fields = ^{flat[6*8 +: 8], flat[9*8 +: 8], flat[1*8+3 +: 5], flat[1*8]};
endmodule

// File: rtl/wvs_range_check.sv
module wvs_range_check
  import wvs_pkg::*;
#(
  parameter int CAP_BLOCKS = 64,
  localparam int CNT_W = $clog2(CAP_BLOCKS + 1)
) (
  input  cmd_t             cmd,
  output logic             op_ok,
  output logic             legal,
  output logic [CNT_W-1:0] nblocks
);
  localparam logic [32:0] CAP_X = 33'(CAP_BLOCKS);

  logic        is_wrv;
  logic        ws_eff;
  logic [32:0] lba_x;
  logic [32:0] end_x;

  always_comb begin
    is_wrv  = (cmd.opcode == OP_WRV);
    op_ok   = is_wrv || (cmd.opcode == OP_VFY);
    ws_eff  = is_wrv && cmd.wsame;
    lba_x   = {1'b0, cmd.lba};
    end_x   = lba_x + {17'b0, cmd.count};
    legal   = 1'b1;
    nblocks = '0;
    if (ws_eff && cmd.count == 16'd0) begin
      legal   = (lba_x < CAP_X);
      nblocks = CNT_W'(CAP_X - lba_x);
    end else if (cmd.count != 16'd0) begin
      legal   = (end_x <= CAP_X);
      nblocks = CNT_W'(cmd.count);
    end
  end
endmodule

// File: rtl/wvs_blk_buf.sv
module wvs_blk_buf #(
  parameter int BLK_BYTES = 16,
  localparam int OFF_W = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [OFF_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem_q [BLK_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wv_cmd_sequencer.sv
module wv_cmd_sequencer
  import wvs_pkg::*;
#(
  parameter int BLK_BYTES  = 16,
  parameter int CAP_BLOCKS = 64,
  localparam int LBA_W = $clog2(CAP_BLOCKS),
  localparam int OFF_W = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cdb_valid,
  output logic             cdb_ready,
  input  logic [7:0]       cdb_byte,
  input  logic             dout_valid,
  output logic             dout_ready,
  input  logic [7:0]       dout_byte,
  output logic             med_we,
  output logic             med_re,
  output logic [LBA_W-1:0] med_lba,
  output logic [OFF_W-1:0] med_off,
  output logic [7:0]       med_wdata,
  input  logic [7:0]       med_rdata,
  input  logic             med_chk_ok,
  output logic             done,
  output logic [7:0]       status,
  output logic [3:0]       sense
);
  localparam int CNT_W = $clog2(CAP_BLOCKS + 1);
  localparam int RXC_W = $clog2(BLK_BYTES + 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_BYTES - 1);

  logic rst_ns;
  wvs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  seq_state_e       state_q, state_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [LBA_W-1:0] lba_q, lba_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             vfy_q, vfy_d;
  logic             wsame_q, wsame_d;
  logic             bytchk_q, bytchk_d;
  logic [7:0]       status_q, status_d;
  logic [3:0]       sense_q, sense_d;
  logic             ctl_en;

  cmd_t             cmd;
  logic             cdb_last;
  logic             op_ok, legal;
  logic [CNT_W-1:0] nblocks;
  logic             buf_we;
  logic [7:0]       buf_rdata;
  logic             off_end;

  wvs_cdb_capture u_cdb (
    .clk(clk), .rst_n(rst_ns), .en(state_q == S_IDLE),
    .in_valid(cdb_valid), .in_byte(cdb_byte), .in_ready(cdb_ready),
    .last_take(cdb_last), .cmd(cmd)
  );

  wvs_range_check #(.CAP_BLOCKS(CAP_BLOCKS)) u_rng (
    .cmd(cmd), .op_ok(op_ok), .legal(legal), .nblocks(nblocks)
  );

  wvs_blk_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
    .clk(clk), .we(buf_we), .waddr(off_q), .wdata(dout_byte),
    .raddr(off_q), .rdata(buf_rdata)
  );

  assign off_end   = (off_q == OFF_LAST);
  assign med_lba   = lba_q;
  assign med_off   = off_q;
  assign med_wdata = buf_rdata;
  assign status    = status_q;
  assign sense     = sense_q;

  // next-state process
  always_comb begin
    state_d    = state_q;
    off_d      = off_q;
    lba_d      = lba_q;
    remain_d   = remain_q;
    vfy_d      = vfy_q;
    wsame_d    = wsame_q;
    bytchk_d   = bytchk_q;
    status_d   = status_q;
    sense_d    = sense_q;
    dout_ready = 1'b0;
    buf_we     = 1'b0;
    med_we     = 1'b0;
    med_re     = 1'b0;
    done       = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cdb_last) state_d = S_DECODE;
      end
      S_DECODE: begin
        vfy_d    = (cmd.opcode == OP_VFY);
        wsame_d  = cmd.wsame && (cmd.opcode == OP_WRV);
        bytchk_d = cmd.bytchk;
        lba_d    = cmd.lba[LBA_W-1:0];
        remain_d = nblocks;
        off_d    = '0;
        status_d = ST_GOOD;
        sense_d  = SK_NONE;
        if (!op_ok || !legal) begin
          status_d = ST_CHECK;
          sense_d  = SK_ILLEGAL;
          state_d  = S_DONE;
        end else if (nblocks == '0) begin
          state_d = S_DONE;
        end else if (cmd.opcode == OP_VFY && !cmd.bytchk) begin
          state_d = S_VERIFY;
        end else begin
          state_d = S_RECV;
        end
      end
      S_RECV: begin
        dout_ready = 1'b1;
        buf_we     = dout_valid;
        if (dout_valid) begin
          off_d = off_q + 1'b1;
          if (off_end) begin
            off_d   = '0;
            state_d = vfy_q ? S_VERIFY : S_WRITE;
          end
        end
      end
      S_WRITE: begin
        med_we = 1'b1;
        off_d  = off_q + 1'b1;
        if (off_end) begin
          off_d   = '0;
          state_d = S_VERIFY;
        end
      end
      S_VERIFY: begin
        med_re = 1'b1;
        off_d  = off_q + 1'b1;
        if (bytchk_q && (med_rdata != buf_rdata)) begin
          status_d = ST_CHECK;
          sense_d  = SK_MISCMP;
          state_d  = S_DONE;
        end else if (!bytchk_q && !med_chk_ok) begin
          status_d = ST_CHECK;
          sense_d  = SK_MEDIUM;
          state_d  = S_DONE;
        end else if (off_end) begin
          off_d    = '0;
          remain_d = remain_q - 1'b1;
          lba_d    = lba_q + 1'b1;
          if (remain_q == CNT_W'(1))  state_d = S_DONE;
          else if (vfy_q)             state_d = bytchk_q ? S_RECV : S_VERIFY;
          else                        state_d = wsame_q ? S_WRITE : S_RECV;
        end
      end
      S_DONE: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // control registers advance only outside idle
  assign ctl_en = (state_q != S_IDLE);

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= S_IDLE;
      off_q    <= '0;
      lba_q    <= '0;
      remain_q <= '0;
      vfy_q    <= 1'b0;
      wsame_q  <= 1'b0;
      bytchk_q <= 1'b0;
      status_q <= ST_GOOD;
      sense_q  <= SK_NONE;
    end else begin
      state_q <= state_d;
      if (ctl_en) begin
        off_q    <= off_d;
        lba_q    <= lba_d;
        remain_q <= remain_d;
        vfy_q    <= vfy_d;
        wsame_q  <= wsame_d;
        bytchk_q <= bytchk_d;
        status_q <= status_d;
        sense_q  <= sense_d;
      end
    end
  end

  // checker counter: data bytes taken since the descriptor was decoded
  logic [RXC_W-1:0] rx_cnt_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                                   rx_cnt_q <= '0;
    else if (state_q == S_DECODE)                  rx_cnt_q <= '0;
    else if (dout_valid && dout_ready &&
             rx_cnt_q != RXC_W'(BLK_BYTES))        rx_cnt_q <= rx_cnt_q + 1'b1;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  assert_good_no_sense_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && status == ST_GOOD) |-> (sense == SK_NONE));

  assert_miscompare_check_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && sense == SK_MISCMP) |-> (status == ST_CHECK));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == S_DECODE && !legal) |=> (done && !med_we && !dout_ready));

  assert_zero_len_done_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == S_DECODE && op_ok && legal && nblocks == '0) |=> (done && status == ST_GOOD));

  assert_wsame_one_block_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (wsame_q && !vfy_q && dout_valid && dout_ready) |-> (rx_cnt_q < RXC_W'(BLK_BYTES)));
endmodule

// File: tb/test_wv_cmd_sequencer.sv
`timescale 1ns/1ps
module test_wv_cmd_sequencer;
  localparam int BLK = 16;
  localparam int CAP = 64;
  localparam int LBA_W = $clog2(CAP);
  localparam int OFF_W = $clog2(BLK);

  logic clk, rst_n;
  logic cdb_valid, cdb_ready;
  logic [7:0] cdb_byte;
  logic dout_valid, dout_ready;
  logic [7:0] dout_byte;
  logic med_we, med_re, med_chk_ok, done;
  logic [LBA_W-1:0] med_lba;
  logic [OFF_W-1:0] med_off;
  logic [7:0] med_wdata, med_rdata, status;
  logic [3:0] sense;

  wv_cmd_sequencer #(.BLK_BYTES(BLK), .CAP_BLOCKS(CAP)) i_wv_cmd_sequencer (
    .clk(clk), .rst_n(rst_n),
    .cdb_valid(cdb_valid), .cdb_ready(cdb_ready), .cdb_byte(cdb_byte),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_byte(dout_byte),
    .med_we(med_we), .med_re(med_re), .med_lba(med_lba), .med_off(med_off),
    .med_wdata(med_wdata), .med_rdata(med_rdata), .med_chk_ok(med_chk_ok),
    .done(done), .status(status), .sense(sense)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] mem [0:CAP*BLK-1];
  logic [7:0] tx  [0:63];
  int flip_lba = -1;
  int flip_off = 0;
  int wr_count = 0;
  int n_chk = 0;
  int n_fail = 0;
  int got_acc;
  int got_wr;
  logic [7:0] got_st;
  logic [3:0] got_sk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CAP*BLK; i++) mem[i] <= 8'h00;
    end else if (med_we) begin
      mem[{med_lba, med_off}] <= (int'(med_lba) == flip_lba && int'(med_off) == flip_off)
                                 ? (med_wdata ^ 8'h01) : med_wdata;
      wr_count <= wr_count + 1;
    end
  end
  assign med_rdata = mem[{med_lba, med_off}];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic send_cdb(input logic [7:0] op, input logic [7:0] b1,
                          input logic [31:0] lba, input logic [15:0] cnt);
    logic [7:0] b [10];
    b = '{op, b1, lba[31:24], lba[23:16], lba[15:8], lba[7:0], 8'hFF,
          cnt[15:8], cnt[7:0], 8'hC3};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cdb_valid = 1'b1;
      cdb_byte  = b[k];
      while (!cdb_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dout_valid = 1'b1;
      dout_byte  = tx[i];
      while (!dout_ready && !done) @(negedge clk);
      if (!dout_ready) break;
      @(posedge clk);
      got_acc++;
    end
    @(negedge clk);
    dout_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    @(negedge clk);
    while (!done && t < 4000) begin
      @(negedge clk);
      t++;
    end
    got_st = status;
    got_sk = sense;
    if (!done) chk("R11", "completion seen", 0, 1);
    else       chk("R11", "cdb_ready low at done", int'(cdb_ready), 0);
    @(negedge clk);
    chk("R11", "done single cycle", int'(done), 0);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] b1,
                         input logic [31:0] lba, input logic [15:0] cnt, input int n);
    int w0;
    w0 = wr_count;
    got_acc = 0;
    send_cdb(op, b1, lba, cnt);
    fork
      feed(n);
      wait_done();
    join
    got_wr = wr_count - w0;
  endtask

  task automatic fill_tx(input logic [7:0] base, input int period);
    for (int i = 0; i < 64; i++) tx[i] = base + 8'((i % period) * 7);
  endtask

  function automatic int block_bad(input int lba, input int nblk);
    int bad = 0;
    for (int b = 0; b < nblk; b++)
      for (int o = 0; o < BLK; o++)
        if (mem[(lba + b) * BLK + o] !== tx[o]) bad++;
    return bad;
  endfunction

  // R1, R11: reset state
  task automatic t_reset();
    chk("R1", "cdb_ready after reset", int'(cdb_ready), 1);
    chk("R11", "done after reset", int'(done), 0);
    chk("R3", "no write after reset", int'(med_we), 0);
    chk("R3", "dout_ready after reset", int'(dout_ready), 0);
  endtask

  // R1, R3: write-and-verify of two blocks; ignored bits set in byte 1, 6 and 9
  task automatic t_write_verify();
    int bad = 0;
    for (int i = 0; i < 64; i++) tx[i] = 8'(i * 7 + 3);
    run_cmd(8'h2E, 8'hF2, 32'd5, 16'd2, 32);
    chk("R3", "status", got_st, 8'h00);
    chk("R3", "sense", got_sk, 4'h0);
    chk("R3", "bytes taken", got_acc, 32);
    chk("R3", "bytes written", got_wr, 32);
    for (int i = 0; i < 32; i++) if (mem[5*BLK + i] !== tx[i]) bad++;
    chk("R1", "stored data at blocks 5..6", bad, 0);
  endtask

  // R4: miscompare in second of three blocks
  task automatic t_miscompare();
    fill_tx(8'h11, 16);
    flip_lba = 11; flip_off = 3;
    run_cmd(8'h2E, 8'h02, 32'd10, 16'd3, 48);
    chk("R4", "status", got_st, 8'h02);
    chk("R4", "sense", got_sk, 4'hE);
    chk("R4", "bytes written", got_wr, 32);
    chk("R4", "bytes taken", got_acc, 32);
  endtask

  // R5: no compare without byte-check; medium-check input
  task automatic t_medium_check();
    fill_tx(8'h22, 16);
    run_cmd(8'h2E, 8'h00, 32'd11, 16'd1, 16);
    chk("R5", "corrupt byte, no compare: status", got_st, 8'h00);
    flip_lba = -1;
    med_chk_ok = 1'b0;
    run_cmd(8'h2E, 8'h00, 32'd30, 16'd2, 32);
    chk("R5", "medium fail status", got_st, 8'h02);
    chk("R5", "medium fail sense", got_sk, 4'h3);
    chk("R5", "medium fail writes", got_wr, 16);
    run_cmd(8'h2E, 8'h02, 32'd32, 16'd1, 16);
    chk("R5", "byte-check ignores medium input: status", got_st, 8'h00);
    med_chk_ok = 1'b1;
  endtask

  // R6: zero count without write-same
  task automatic t_zero_len();
    fill_tx(8'h33, 16);
    run_cmd(8'h2E, 8'h02, 32'd40, 16'd0, 16);
    chk("R6", "write zero status", got_st, 8'h00);
    chk("R6", "write zero bytes taken", got_acc, 0);
    chk("R6", "write zero writes", got_wr, 0);
    run_cmd(8'h2F, 8'h02, 32'd40, 16'd0, 16);
    chk("R6", "verify zero status", got_st, 8'h00);
    chk("R6", "verify zero bytes taken", got_acc, 0);
  endtask

  // R7: write-same over four blocks
  task automatic t_write_same();
    fill_tx(8'hA0, 16);
    run_cmd(8'h2E, 8'h06, 32'd20, 16'd4, 32);
    chk("R7", "status", got_st, 8'h00);
    chk("R7", "bytes taken", got_acc, 16);
    chk("R7", "bytes written", got_wr, 64);
    chk("R7", "blocks 20..23 content", block_bad(20, 4), 0);
  endtask

  // R8: write-same, zero count, runs to the last block
  task automatic t_write_same_end();
    fill_tx(8'h5A, 16);
    run_cmd(8'h2E, 8'h04, 32'd60, 16'd0, 16);
    chk("R8", "status", got_st, 8'h00);
    chk("R8", "bytes written", got_wr, 64);
    chk("R8", "blocks 60..63 content", block_bad(60, 4), 0);
  endtask

  // R9: capacity checks
  task automatic t_range();
    fill_tx(8'h44, 16);
    run_cmd(8'h2E, 8'h02, 32'd62, 16'd3, 48);
    chk("R9", "overrun status", got_st, 8'h02);
    chk("R9", "overrun sense", got_sk, 4'h5);
    chk("R9", "overrun writes", got_wr, 0);
    chk("R9", "overrun bytes taken", got_acc, 0);
    run_cmd(8'h2E, 8'h04, 32'd64, 16'd0, 16);
    chk("R9", "write-same start past end sense", got_sk, 4'h5);
    run_cmd(8'h2E, 8'h02, 32'h0001_0005, 16'd1, 16);
    chk("R9", "high address bytes sense", got_sk, 4'h5);
    chk("R9", "high address writes", got_wr, 0);
    run_cmd(8'h2E, 8'h02, 32'd62, 16'd2, 32);
    chk("R9", "exact fit status", got_st, 8'h00);
    chk("R9", "exact fit writes", got_wr, 32);
  endtask

  // R2: unknown opcode
  task automatic t_bad_op();
    run_cmd(8'h2A, 8'h02, 32'd1, 16'd1, 16);
    chk("R2", "status", got_st, 8'h02);
    chk("R2", "sense", got_sk, 4'h5);
    chk("R2", "writes", got_wr, 0);
    chk("R2", "bytes taken", got_acc, 0);
  endtask

  // R10: verify command
  task automatic t_verify();
    fill_tx(8'hA0, 16);
    run_cmd(8'h2F, 8'h02, 32'd20, 16'd2, 32);
    chk("R10", "match status", got_st, 8'h00);
    chk("R10", "match bytes taken", got_acc, 32);
    chk("R10", "match writes", got_wr, 0);
    tx[20] = tx[20] ^ 8'h80;
    run_cmd(8'h2F, 8'h02, 32'd20, 16'd2, 32);
    chk("R10", "mismatch status", got_st, 8'h02);
    chk("R10", "mismatch sense", got_sk, 4'hE);
    run_cmd(8'h2F, 8'h04, 32'd0, 16'd3, 16);
    chk("R10", "no byte-check status", got_st, 8'h00);
    chk("R10", "no byte-check bytes taken", got_acc, 0);
    chk("R10", "no byte-check writes", got_wr, 0);
  endtask

  // R4 with R3: mismatch on last byte of last block
  task automatic t_last_byte();
    fill_tx(8'h66, 16);
    flip_lba = 50; flip_off = 15;
    run_cmd(8'h2E, 8'h02, 32'd50, 16'd1, 16);
    chk("R4", "last byte mismatch status", got_st, 8'h02);
    chk("R4", "last byte mismatch sense", got_sk, 4'hE);
    flip_lba = -1;
  endtask

  initial begin
    rst_n = 1'b0;
    cdb_valid = 1'b0; cdb_byte = 8'h00;
    dout_valid = 1'b0; dout_byte = 8'h00;
    med_chk_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_verify();
    t_miscompare();
    t_medium_check();
    t_zero_len();
    t_write_same();
    t_write_same_end();
    t_range();
    t_bad_op();
    t_verify();
    t_last_byte();
    finish_run();
  end
endmodule